// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block holds a 64-bit interrupt command, written as a low and a high 32-bit word, and turns every write of the low word into a delivery request aimed at up to `N_UNITS` processor-local interrupt units. The high word supplies the 8-bit destination. The low word supplies the vector, the delivery mode, the destination mode, the trigger mode and a shorthand that can override the destination. The block resolves these into a per-unit target mask, prunes the mask, and raises one-cycle strobes that match the requested delivery mode.

In logical destination mode, each receiver reports through one input bit whether its own logical address matches. Lowest-priority requests are not resolved here. The block hands the candidate mask and the vector to an external arbiter. Sends that end with no target, and sends that use an unsupported mode, are recorded as sticky bits in an error status register. Software clears that register by writing to it.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, both command words and the error status read 0, and every request strobe, `lowpri_valid` and `send_accepted` are low.
- R2: `wr_sel` selects the target of a write: 0 is the low word, 1 is the high word, 2 is the error status, and 3 is ignored. The high word is stored exactly as written. The low word is stored with bit 12 forced to 0.
- R3: The low word is laid out as follows: vector in bits [7:0], delivery mode in [10:8], destination mode in bit 11 (1 = logical), trigger mode in bit 15 and shorthand in [19:18]. The destination is taken from bits [31:24] of the stored high word. Delivery modes are 0 fixed, 1 lowest priority, 4 NMI, 5 INIT and 6 start-up. Strobes, `out_vector` and `send_accepted` appear in the cycle after the low-word write and last exactly one cycle.
- R4: With shorthand 0 in physical mode, destination D selects unit D alone. Destination 0xFF selects every unit. Any other D of `N_UNITS` or more selects no unit.
- R5: With shorthand 0 in logical mode, destination 0 selects no unit. Any other destination selects exactly the units whose `logical_match` bit is 1.
- R6: Shorthand overrides the destination: 1 selects only the unit numbered `self_id`, 2 selects all units, and 3 selects all units except `self_id`.
- R7: Units whose `unit_present` bit is 0 never receive a strobe and never appear in `lowpri_cand`.
- R8: A fixed send pulses `fixed_req` for every unit in the mask, all in the same cycle. The vector is carried on `out_vector`. Only one kind of strobe is raised per send.
- R9: A lowest-priority send raises `lowpri_valid` with `lowpri_cand` set to the mask restricted to started units. No per-unit strobe is raised for it.
- R10: An NMI send pulses `nmi_req` only on units in the mask whose `unit_started` bit is 1.
- R11: An INIT send pulses `init_req` over the mask. A start-up send pulses `sipi_req` over the mask, with the vector on `out_vector`.
- R12: When a supported send ends with an empty mask, `send_accepted` stays low and error status bit 0 is set. The bit stays set until it is cleared. A send with a non-empty mask pulses `send_accepted`.
- R13: Delivery modes 2, 3 and 7 raise no strobe and no `send_accepted`, and they set error status bit 1.
- R14: Any write to the error status clears both of its bits, whatever the data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 low word, 1 high word, 2 error status |
| wr_data | input | 32 | Write data |
| self_id | input | 4 | Number of the sending unit |
| unit_present | input | 16 | Units that exist |
| unit_started | input | 16 | Units whose processor has been started |
| logical_match | input | 16 | Per-unit logical destination match |
| cmd_lo | output | 32 | Stored low command word |
| cmd_hi | output | 32 | Stored high command word |
| err_status | output | 8 | Bit 0 accept error, bit 1 unsupported mode |
| fixed_req | output | 16 | Fixed-delivery request strobes |
| nmi_req | output | 16 | Pending-NMI strobes |
| init_req | output | 16 | INIT strobes |
| sipi_req | output | 16 | Start-up strobes |
| lowpri_valid | output | 1 | Lowest-priority request to the arbiter |
| lowpri_cand | output | 16 | Candidate units for the arbiter |
| out_vector | output | 8 | Vector of the current send |
| send_accepted | output | 1 | Send reached at least one unit |

## Verification
The assertions on presence and start state compare the strobes against the values of `unit_present` and `unit_started` one cycle earlier. They therefore assume that these inputs were defined during the write cycle and changed no sooner than that cycle. The stimulus changes those inputs only between sends, on the falling edge, and drives every input from time zero. The strobe-origin check assumes that only a low-word write launches a request. The bench never drives `wr_sel` 0 except through its send task.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_RSV2   = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_RSV7   = 3'd7
    } dmode_e;

    localparam logic [1:0] SEL_LO  = 2'd0;
    localparam logic [1:0] SEL_HI  = 2'd1;
    localparam logic [1:0] SEL_ERR = 2'd2;

    localparam int ERR_W        = 8;
    localparam int ERR_ACCEPT   = 0;
    localparam int ERR_BADMODE  = 1;
    localparam int STATUS_BIT   = 12;

    localparam logic [1:0] SH_NONE  = 2'd0;
    localparam logic [1:0] SH_SELF  = 2'd1;
    localparam logic [1:0] SH_ALL   = 2'd2;
    localparam logic [1:0] SH_OTHER = 2'd3;

endpackage

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
    import ipi_pkg::*;
#(
    parameter int N_UNITS = 16,
    parameter int ID_W    = 4
) (
    input  logic [7:0]         dest,
    input  logic               logical,
    input  logic [1:0]         shorthand,
    input  logic [ID_W-1:0]    self_id,
    input  logic [N_UNITS-1:0] present,
    input  logic [N_UNITS-1:0] match,
    output logic [N_UNITS-1:0] mask
);
    logic [N_UNITS-1:0] phys_hit;
    logic [N_UNITS-1:0] self_hit;
    logic [N_UNITS-1:0] raw_mask;

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        assign phys_hit[i] = (dest == 8'(i)) || (dest == 8'hFF);
        assign self_hit[i] = (self_id == ID_W'(i));
    end

    always_comb begin
        unique case (shorthand)
            SH_SELF:  raw_mask = self_hit;
            SH_ALL:   raw_mask = '1;
            SH_OTHER: raw_mask = ~self_hit;
            default: begin
                if (logical) raw_mask = (dest == 8'h00) ? '0 : match;
                else         raw_mask = phys_hit;
            end
        endcase
    end

    assign mask = raw_mask & present;

endmodule

// File: rtl/ipi_mode_route.sv
module ipi_mode_route
    import ipi_pkg::*;
#(
    parameter int N_UNITS = 16
) (
    input  logic               fire,
    input  dmode_e             mode,
    input  logic [N_UNITS-1:0] mask,
    input  logic [N_UNITS-1:0] started,
    output logic [N_UNITS-1:0] fixed_o,
    output logic [N_UNITS-1:0] nmi_o,
    output logic [N_UNITS-1:0] init_o,
    output logic [N_UNITS-1:0] sipi_o,
    output logic [N_UNITS-1:0] lp_cand_o,
    output logic               lp_valid_o,
    output logic               empty_o,
    output logic               bad_mode_o
);
    logic [N_UNITS-1:0] live_mask;

    assign live_mask = mask & started;

    always_comb begin
        fixed_o    = '0;
        nmi_o      = '0;
        init_o     = '0;
        sipi_o     = '0;
        lp_cand_o  = '0;
        lp_valid_o = 1'b0;
        empty_o    = 1'b0;
        bad_mode_o = 1'b0;
        if (fire) begin
            unique case (mode)
                DM_FIXED: begin
                    fixed_o = mask;
                    empty_o = ~|mask;
                end
                DM_LOWPRI: begin
                    lp_cand_o  = live_mask;
                    lp_valid_o = |live_mask;
                    empty_o    = ~|live_mask;
                end
                DM_NMI: begin
                    nmi_o   = live_mask;
                    empty_o = ~|live_mask;
                end
                DM_INIT: begin
                    init_o  = mask;
                    empty_o = ~|mask;
                end
                DM_START: begin
                    sipi_o  = mask;
                    empty_o = ~|mask;
                end
                default: bad_mode_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int N_UNITS = 16,
    parameter int VEC_W   = 8,
    localparam int ID_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [31:0]        wr_data,
    input  logic [ID_W-1:0]    self_id,
    input  logic [N_UNITS-1:0] unit_present,
    input  logic [N_UNITS-1:0] unit_started,
    input  logic [N_UNITS-1:0] logical_match,
    output logic [31:0]        cmd_lo,
    output logic [31:0]        cmd_hi,
    output logic [ERR_W-1:0]   err_status,
    output logic [N_UNITS-1:0] fixed_req,
    output logic [N_UNITS-1:0] nmi_req,
    output logic [N_UNITS-1:0] init_req,
    output logic [N_UNITS-1:0] sipi_req,
    output logic               lowpri_valid,
    output logic [N_UNITS-1:0] lowpri_cand,
    output logic [VEC_W-1:0]   out_vector,
    output logic               send_accepted
);
    typedef struct packed {
        logic [31:0]        lo;
        logic [31:0]        hi;
        logic [ERR_W-1:0]   err;
        logic [N_UNITS-1:0] fixed;
        logic [N_UNITS-1:0] nmi;
        logic [N_UNITS-1:0] init;
        logic [N_UNITS-1:0] sipi;
        logic [N_UNITS-1:0] lpc;
        logic               lpv;
        logic [VEC_W-1:0]   vec;
        logic               ok;
    } state_t;

    state_t st_d, st_q;

    logic               fire;
    logic [N_UNITS-1:0] tgt_mask;
    logic [N_UNITS-1:0] r_fixed, r_nmi, r_init, r_sipi, r_lpc;
    logic               r_lpv, r_empty, r_bad;
    dmode_e             mode;

    assign fire = wr_en && (wr_sel == SEL_LO);
    assign mode = dmode_e'(wr_data[10:8]);

    ipi_dest_decode #(
        .N_UNITS (N_UNITS),
        .ID_W    (ID_W)
    ) u_decode (
        .dest      (st_q.hi[31:24]),
        .logical   (wr_data[11]),
        .shorthand (wr_data[19:18]),
        .self_id   (self_id),
        .present   (unit_present),
        .match     (logical_match),
        .mask      (tgt_mask)
    );

    ipi_mode_route #(
        .N_UNITS (N_UNITS)
    ) u_route (
        .fire       (fire),
        .mode       (mode),
        .mask       (tgt_mask),
        .started    (unit_started),
        .fixed_o    (r_fixed),
        .nmi_o      (r_nmi),
        .init_o     (r_init),
        .sipi_o     (r_sipi),
        .lp_cand_o  (r_lpc),
        .lp_valid_o (r_lpv),
        .empty_o    (r_empty),
        .bad_mode_o (r_bad)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fixed = r_fixed;
        st_d.nmi   = r_nmi;
        st_d.init  = r_init;
        st_d.sipi  = r_sipi;
        st_d.lpc   = r_lpc;
        st_d.lpv   = r_lpv;
        st_d.ok    = fire && !r_empty && !r_bad;
        if (fire) begin
            st_d.vec = wr_data[VEC_W-1:0];
        end
        if (wr_en) begin
            unique case (wr_sel)
                SEL_LO: begin
                    st_d.lo             = wr_data;
                    st_d.lo[STATUS_BIT] = 1'b0;
                    if (r_empty) st_d.err[ERR_ACCEPT]  = 1'b1;
                    if (r_bad)   st_d.err[ERR_BADMODE] = 1'b1;
                end
                SEL_HI:  st_d.hi  = wr_data;
                SEL_ERR: st_d.err = '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_lo        = st_q.lo;
    assign cmd_hi        = st_q.hi;
    assign err_status    = st_q.err;
    assign fixed_req     = st_q.fixed;
    assign nmi_req       = st_q.nmi;
    assign init_req      = st_q.init;
    assign sipi_req      = st_q.sipi;
    assign lowpri_valid  = st_q.lpv;
    assign lowpri_cand   = st_q.lpc;
    assign out_vector    = st_q.vec;
    assign send_accepted = st_q.ok;

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk
    import ipi_pkg::*;
#(
    parameter int N_UNITS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [N_UNITS-1:0] unit_present,
    input logic [N_UNITS-1:0] unit_started,
    input logic [31:0]        cmd_lo,
    input logic [ERR_W-1:0]   err_status,
    input logic [N_UNITS-1:0] fixed_req,
    input logic [N_UNITS-1:0] nmi_req,
    input logic [N_UNITS-1:0] init_req,
    input logic [N_UNITS-1:0] sipi_req,
    input logic               lowpri_valid,
    input logic [N_UNITS-1:0] lowpri_cand,
    input logic               send_accepted
);
    logic [N_UNITS-1:0] any_tgt;
    logic               any_strobe;

    assign any_tgt    = fixed_req | nmi_req | init_req | sipi_req | lowpri_cand;
    assign any_strobe = (|fixed_req) | (|nmi_req) | (|init_req) | (|sipi_req) | lowpri_valid;

    AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lo[STATUS_BIT] == 1'b0); // R2

    AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> $past(wr_en && wr_sel == SEL_LO)); // R3

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|fixed_req, |nmi_req, |init_req, |sipi_req, lowpri_valid})); // R8

    AST_PRESENT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (any_tgt & ~$past(unit_present)) == '0); // R7

    AST_NMI_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req & ~$past(unit_started)) == '0); // R10

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_sel == SEL_ERR) |-> err_status == '0); // R14

    AST_ACCEPT_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        send_accepted |-> any_strobe); // R12

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .unit_present  (unit_present),
    .unit_started  (unit_started),
    .cmd_lo        (cmd_lo),
    .err_status    (err_status),
    .fixed_req     (fixed_req),
    .nmi_req       (nmi_req),
    .init_req      (init_req),
    .sipi_req      (sipi_req),
    .lowpri_valid  (lowpri_valid),
    .lowpri_cand   (lowpri_cand),
    .send_accepted (send_accepted)
);

// File: tb/ipi_dispatch_bench.sv
module ipi_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [3:0]  self_id = 4'd3;
    logic [15:0] unit_present = 16'hFFFF;
    logic [15:0] unit_started = 16'hFFFF;
    logic [15:0] logical_match = 16'h0000;
    logic [31:0] cmd_lo, cmd_hi;
    logic [7:0]  err_status;
    logic [15:0] fixed_req, nmi_req, init_req, sipi_req, lowpri_cand;
    logic        lowpri_valid, send_accepted;
    logic [7:0]  out_vector;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ipi_dispatch u_ipi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .self_id(self_id), .unit_present(unit_present), .unit_started(unit_started),
        .logical_match(logical_match), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .err_status(err_status), .fixed_req(fixed_req), .nmi_req(nmi_req),
        .init_req(init_req), .sipi_req(sipi_req), .lowpri_valid(lowpri_valid),
        .lowpri_cand(lowpri_cand), .out_vector(out_vector), .send_accepted(send_accepted)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] mode,
                                            input logic dm, input logic [1:0] sh);
        return {12'b0, sh, 2'b0, 1'b0, 3'b0, dm, mode, vec};
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_dest(input logic [7:0] d);
        wr(2'd1, {d, 24'h0});
    endtask

    task automatic clear_err();
        wr(2'd2, 32'h0000_00FF);
        check("R14 clear", err_status, 8'h00);
    endtask

    task automatic t_reset();
        check("R1 cmd_lo", cmd_lo, 0);
        check("R1 cmd_hi", cmd_hi, 0);
        check("R1 err", err_status, 0);
        check("R1 strobes", {fixed_req, nmi_req, init_req, sipi_req, lowpri_valid, send_accepted}, 0);
    endtask

    task automatic t_regs();
        wr(2'd1, 32'h05AB_CDEF);
        check("R2 hi word", cmd_hi, 32'h05AB_CDEF);
        wr(2'd0, 32'hFFFF_FFFF);
        check("R2 lo bit12 forced", cmd_lo, 32'hFFFF_EFFF);
        check("R13 mode7 err", err_status, 8'h02);
        wr(2'd3, 32'h1234_5678);
        check("R2 sel3 ignored", {cmd_lo, cmd_hi}, {32'hFFFF_EFFF, 32'h05AB_CDEF});
        clear_err();
    endtask

    task automatic t_phys();
        set_dest(8'd5);
        wr(2'd0, lo_word(8'h41, 3'd0, 1'b0, 2'd0));
        check("R4 R8 phys fixed", fixed_req, 16'h0020);
        check("R3 vector", out_vector, 8'h41);
        check("R12 accepted", send_accepted, 1'b1);
        @(negedge clk);
        check("R3 one-cycle pulse", {fixed_req, send_accepted}, 0);
        set_dest(8'hFF);
        wr(2'd0, lo_word(8'h42, 3'd0, 1'b0, 2'd0));
        check("R4 broadcast", fixed_req, 16'hFFFF);
        set_dest(8'h14);
        wr(2'd0, lo_word(8'h43, 3'd0, 1'b0, 2'd0));
        check("R4 out of range", fixed_req, 16'h0000);
        check("R12 accept error", {err_status, send_accepted}, {8'h01, 1'b0});
        @(negedge clk);
        check("R12 sticky", err_status, 8'h01);
        clear_err();
    endtask

    task automatic t_logical();
        logical_match = 16'h0A05;
        set_dest(8'h0F);
        wr(2'd0, lo_word(8'h50, 3'd0, 1'b1, 2'd0));
        check("R5 logical match", fixed_req, 16'h0A05);
        set_dest(8'h00);
        wr(2'd0, lo_word(8'h51, 3'd0, 1'b1, 2'd0));
        check("R5 logical zero", {fixed_req, err_status}, {16'h0, 8'h01});
        clear_err();
        logical_match = 16'h0;
    endtask

    task automatic t_short();
        set_dest(8'd5);
        wr(2'd0, lo_word(8'h60, 3'd0, 1'b0, 2'd1));
        check("R6 self", fixed_req, 16'h0008);
        wr(2'd0, lo_word(8'h61, 3'd0, 1'b0, 2'd2));
        check("R6 all", fixed_req, 16'hFFFF);
        wr(2'd0, lo_word(8'h62, 3'd0, 1'b0, 2'd3));
        check("R6 all but self", fixed_req, 16'hFFF7);
    endtask

    task automatic t_present();
        unit_present = 16'h00F0;
        wr(2'd0, lo_word(8'h70, 3'd0, 1'b0, 2'd2));
        check("R7 prune all", fixed_req, 16'h00F0);
        set_dest(8'd2);
        wr(2'd0, lo_word(8'h71, 3'd0, 1'b0, 2'd0));
        check("R7 absent target", {fixed_req, err_status}, {16'h0, 8'h01});
        clear_err();
        unit_present = 16'hFFFF;
    endtask

    task automatic t_lowpri();
        unit_started = 16'h0F00;
        wr(2'd0, lo_word(8'h80, 3'd1, 1'b0, 2'd2));
        check("R9 lowpri", {lowpri_valid, lowpri_cand, fixed_req, out_vector},
              {1'b1, 16'h0F00, 16'h0, 8'h80});
        unit_started = 16'h0000;
        wr(2'd0, lo_word(8'h81, 3'd1, 1'b0, 2'd2));
        check("R9 R12 lowpri none started", {lowpri_valid, err_status}, {1'b0, 8'h01});
        clear_err();
    endtask

    task automatic t_nmi();
        unit_started = 16'h00C3;
        wr(2'd0, lo_word(8'h00, 3'd4, 1'b0, 2'd2));
        check("R10 nmi started only", {nmi_req, fixed_req}, {16'h00C3, 16'h0});
        set_dest(8'd2);
        wr(2'd0, lo_word(8'h00, 3'd4, 1'b0, 2'd0));
        check("R10 nmi unstarted", {nmi_req, err_status}, {16'h0, 8'h01});
        clear_err();
        unit_started = 16'hFFFF;
    endtask

    task automatic t_init_sipi();
        set_dest(8'd7);
        wr(2'd0, lo_word(8'h00, 3'd5, 1'b0, 2'd0));
        check("R11 init", {init_req, sipi_req}, {16'h0080, 16'h0});
        wr(2'd0, lo_word(8'h9A, 3'd6, 1'b0, 2'd0));
        check("R11 start-up", {sipi_req, init_req, out_vector}, {16'h0080, 16'h0, 8'h9A});
    endtask

    task automatic t_badmode();
        wr(2'd0, lo_word(8'h10, 3'd2, 1'b0, 2'd2));
        check("R13 mode2", {fixed_req, nmi_req, init_req, sipi_req, lowpri_valid, send_accepted, err_status},
              {65'h0, 1'b0, 8'h02});
        clear_err();
        wr(2'd0, lo_word(8'h11, 3'd3, 1'b0, 2'd2));
        check("R13 mode3", {send_accepted, err_status}, {1'b0, 8'h02});
        clear_err();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_phys();
        t_logical();
        t_short();
        t_present();
        t_lowpri();
        t_nmi();
        t_init_sipi();
        t_badmode();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule